// File: doc/BRIEF.md
# Card Window Region Decoder and Strobe Generator

This block sits between a host memory interface and a removable memory/I-O card socket. The host sees a 16 MB window. The three highest window address bits pick one of five regions: common memory, attribute memory, card I/O, the socket's own status/control registers, and a page-register slot. From that region and the host chip select, output enable and write enable, the block produces the card-side strobes. These are the two card enables (low and high byte), the register-space select, memory read and write, I/O read and write with their driver enable, the data buffer enable and direction, and a load pulse for an external page register.

Three socket settings shape the strobes. An I/O-mode bit enables the I/O strobe drivers. A byte-mode bit restricts accesses to the low-byte card enable. The card's write-protect pin suppresses memory writes. All outputs are active-high. An outer wrapper inverts them for active-low pins and applies the I/O driver enable to tri-state buffers. Every output is registered once on the rising clock edge, so each one reflects the inputs sampled at the previous edge.

Top module: `cardwin_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge, whatever the other inputs are.
- R2: When `host_cs` is 0, the outputs `ce_lo`, `ce_hi`, `reg_sel`, `mem_rd`, `mem_wr`, `io_rd`, `io_wr`, `buf_en` and `page_load` are 0.
- R3: `ce_lo` is 1 exactly when `host_cs` is 1 and `win_sel` is 0xx (common), 100 (attribute) or 101 (I/O).
- R4: `ce_hi` is 1 exactly when `host_cs` is 1, `byte_mode` is 0, and `win_sel` is 0xx or 101. It is never 1 for 100.
- R5: `reg_sel` is 1 exactly when `host_cs` is 1 and `win_sel` is 100 or 101.
- R6: `mem_rd` is 1 exactly when `host_cs` and `host_oe` are 1 and `win_sel` is any value other than 101.
- R7: `mem_wr` is 1 exactly when `host_cs` and `host_we` are 1, `card_wp` is 0, and `win_sel` is not 101.
- R8: `io_rd` (or `io_wr`) is 1 exactly when `host_cs` is 1, `win_sel` is 101, and `host_oe` (or `host_we`) is 1.
- R9: `io_drv_en` equals `io_mode`. I/O strobes reach the card only while it is 1.
- R10: `buf_en` is 1 exactly when `host_cs` is 1, either `host_oe` or `host_we` is 1, and `win_sel` is 0xx, 100 or 101. It stays 0 for 110 and 111, so a read of 111 leaves the data bus floating.
- R11: `buf_dir` equals `host_oe` (1 = card toward host).
- R12: `page_load` is 1 exactly when `host_cs` and `host_we` are 1 and `win_sel` is 111.
- R13: Each output changes only at a rising clock edge and reflects the inputs sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sel | input | 3 | Host window address bits 23..21 |
| host_cs | input | 1 | Host chip select |
| host_oe | input | 1 | Host output enable (read) |
| host_we | input | 1 | Host write enable |
| card_wp | input | 1 | Card write-protect pin level |
| io_mode | input | 1 | Socket I/O-mode setting |
| byte_mode | input | 1 | Socket 8-bit-only setting |
| ce_lo | output | 1 | Card enable, low byte |
| ce_hi | output | 1 | Card enable, high byte |
| reg_sel | output | 1 | Card register-space select |
| mem_rd | output | 1 | Card memory output enable |
| mem_wr | output | 1 | Card memory write enable |
| io_rd | output | 1 | Card I/O read strobe |
| io_wr | output | 1 | Card I/O write strobe |
| io_drv_en | output | 1 | Driver enable for the I/O strobes |
| buf_en | output | 1 | Data buffer enable |
| buf_dir | output | 1 | Data buffer direction |
| page_load | output | 1 | Page-register load pulse |

## Verification
The bench drives all 512 combinations of the region bits, strobes and the three socket settings. The gaps it targets are these. A decoder that forgot the attribute region would raise the high-byte enable there. One that forgot byte mode would raise the high-byte enable on a byte card. A missing write-protect gate would write a protected card. A missing I/O-region exclusion would show a memory strobe together with an I/O strobe. The 110 and 111 regions are checked so that a floating read cannot open the data buffer and a page load cannot fire on a read. A separate test moves the inputs between edges to catch an output that bypasses the register stage.

// File: rtl/cardwin_pkg.sv
package cardwin_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    RG_COMMON = 3'd0,
    RG_ATTR   = 3'd1,
    RG_IO     = 3'd2,
    RG_REGS   = 3'd3,
    RG_PAGE   = 3'd4
  } region_t;

  typedef struct packed {
    logic ce_lo;
    logic ce_hi;
    logic reg_sel;
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic io_drv_en;
    logic buf_en;
    logic buf_dir;
    logic page_load;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/cardwin_region_dec.sv
module cardwin_region_dec
  import cardwin_pkg::*;
(
  input  logic [SEL_W-1:0] win_sel,
  output region_t          region
);
  always_comb begin
    if (!win_sel[SEL_W-1]) begin
      region = RG_COMMON;
    end else begin
      case (win_sel[SEL_W-2:0])
        2'b00:   region = RG_ATTR;
        2'b01:   region = RG_IO;
        2'b10:   region = RG_REGS;
        default: region = RG_PAGE;
      endcase
    end
  end
endmodule

// File: rtl/cardwin_strobe_gen.sv
module cardwin_strobe_gen
  import cardwin_pkg::*;
(
  input  region_t region,
  input  logic    host_cs,
  input  logic    host_oe,
  input  logic    host_we,
  input  logic    card_wp,
  input  logic    io_mode,
  input  logic    byte_mode,
  output strobe_t strobes
);
  logic in_common, in_attr, in_io, in_page, card_rg;

  always_comb begin
    in_common = (region == RG_COMMON);
    in_attr   = (region == RG_ATTR);
    in_io     = (region == RG_IO);
    in_page   = (region == RG_PAGE);
    card_rg   = in_common | in_attr | in_io;

    strobes.ce_lo     = host_cs & card_rg;
    strobes.ce_hi     = host_cs & (in_common | in_io) & ~byte_mode;
    strobes.reg_sel   = host_cs & (in_attr | in_io);
    strobes.mem_rd    = host_cs & host_oe & ~in_io;
    strobes.mem_wr    = host_cs & host_we & ~card_wp & ~in_io;
    strobes.io_rd     = host_cs & host_oe & in_io;
    strobes.io_wr     = host_cs & host_we & in_io;
    strobes.io_drv_en = io_mode;
    strobes.buf_en    = host_cs & (host_oe | host_we) & card_rg;
    strobes.buf_dir   = host_oe;
    strobes.page_load = host_cs & host_we & in_page;
  end
endmodule

// File: rtl/cardwin_pipe.sv
module cardwin_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cardwin_decoder.sv
module cardwin_decoder
  import cardwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] win_sel,
  input  logic             host_cs,
  input  logic             host_oe,
  input  logic             host_we,
  input  logic             card_wp,
  input  logic             io_mode,
  input  logic             byte_mode,
  output logic             ce_lo,
  output logic             ce_hi,
  output logic             reg_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             io_rd,
  output logic             io_wr,
  output logic             io_drv_en,
  output logic             buf_en,
  output logic             buf_dir,
  output logic             page_load
);
  region_t region;
  strobe_t next_s, cur_s;

  cardwin_region_dec u_dec (
    .win_sel (win_sel),
    .region  (region)
  );

  cardwin_strobe_gen u_gen (
    .region    (region),
    .host_cs   (host_cs),
    .host_oe   (host_oe),
    .host_we   (host_we),
    .card_wp   (card_wp),
    .io_mode   (io_mode),
    .byte_mode (byte_mode),
    .strobes   (next_s)
  );

  cardwin_pipe #(.W(STROBE_W)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   (next_s),
    .q   (cur_s)
  );

  assign ce_lo     = cur_s.ce_lo;
  assign ce_hi     = cur_s.ce_hi;
  assign reg_sel   = cur_s.reg_sel;
  assign mem_rd    = cur_s.mem_rd;
  assign mem_wr    = cur_s.mem_wr;
  assign io_rd     = cur_s.io_rd;
  assign io_wr     = cur_s.io_wr;
  assign io_drv_en = cur_s.io_drv_en;
  assign buf_en    = cur_s.buf_en;
  assign buf_dir   = cur_s.buf_dir;
  assign page_load = cur_s.page_load;

  // R2
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !host_cs |=> !(ce_lo || ce_hi || reg_sel || mem_rd || mem_wr ||
                   io_rd || io_wr || buf_en || page_load));

  // R4
  attr_no_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (win_sel == 3'b100) |=> !ce_hi);

  // R7
  wp_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    card_wp |=> !mem_wr);

  // R8
  io_excl_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> !(mem_rd || mem_wr));

  // R9
  io_drv_follow_chk: assert property (@(posedge clk) disable iff (rst)
    io_mode |=> io_drv_en);

  // R12
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_we && win_sel == 3'b111) |=> page_load);

  // R10
  page_read_float_chk: assert property (@(posedge clk) disable iff (rst)
    (win_sel[2:1] == 2'b11) |=> !buf_en);
endmodule

// File: tb/cardwin_decoder_bench.sv
module cardwin_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] win_sel = '0;
  logic host_cs = 0, host_oe = 0, host_we = 0;
  logic card_wp = 0, io_mode = 0, byte_mode = 0;
  logic ce_lo, ce_hi, reg_sel, mem_rd, mem_wr, io_rd, io_wr;
  logic io_drv_en, buf_en, buf_dir, page_load;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic       cs;
    logic [10:0] val;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  cardwin_decoder u_cardwin_decoder (
    .clk(clk), .rst(rst), .win_sel(win_sel), .host_cs(host_cs),
    .host_oe(host_oe), .host_we(host_we), .card_wp(card_wp),
    .io_mode(io_mode), .byte_mode(byte_mode), .ce_lo(ce_lo),
    .ce_hi(ce_hi), .reg_sel(reg_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .io_drv_en(io_drv_en), .buf_en(buf_en),
    .buf_dir(buf_dir), .page_load(page_load)
  );

  function automatic logic [10:0] outs();
    return {ce_lo, ce_hi, reg_sel, mem_rd, mem_wr, io_rd, io_wr,
            io_drv_en, buf_en, buf_dir, page_load};
  endfunction

  function automatic string req_of(int b);
    case (b)
      10: return "R3 ce_lo";
      9:  return "R4 ce_hi";
      8:  return "R5 reg_sel";
      7:  return "R6 mem_rd";
      6:  return "R7 mem_wr";
      5:  return "R8 io_rd";
      4:  return "R8 io_wr";
      3:  return "R9 io_drv_en";
      2:  return "R10 buf_en";
      1:  return "R11 buf_dir";
      default: return "R12 page_load";
    endcase
  endfunction

  // expected strobes from the requirement text
  function automatic logic [10:0] model(logic [2:0] a, logic cs, logic oe,
      logic we, logic wp, logic iom, logic bm);
    logic common, attr, io, page, card;
    common = (a[2] == 1'b0);
    attr   = (a == 3'b100);
    io     = (a == 3'b101);
    page   = (a == 3'b111);
    card   = common | attr | io;
    return {cs & card,
            cs & (common | io) & ~bm,
            cs & (attr | io),
            cs & oe & ~io,
            cs & we & ~wp & ~io,
            cs & oe & io,
            cs & we & io,
            iom,
            cs & (oe | we) & card,
            oe,
            cs & we & page};
  endfunction

  task automatic drive(logic [8:0] v);
    @(negedge clk);
    {win_sel, host_cs, host_oe, host_we, card_wp, io_mode, byte_mode} = v;
    exp_q.push_back('{cs: v[5], val: model(v[8:6], v[5], v[4], v[3], v[2], v[1], v[0])});
  endtask

  task automatic check1(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  // monitor: outputs settle one edge after the driver's push
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        item_t it;
        logic [10:0] got;
        it  = exp_q.pop_front();
        got = outs();
        checks++;
        if (got !== it.val) begin
          fails++;
          for (int b = 0; b < 11; b++)
            if (got[b] !== it.val[b])
              $display("FAIL %s actual=%b expected=%b", req_of(b), got[b], it.val[b]);
        end
        if (!it.cs) begin
          // R2 card strobes idle without chip select
          checks++;
          if ((got & 11'b111_1111_0101) != 0) begin
            fails++;
            $display("FAIL R2 actual=%b expected=%b", got & 11'b111_1111_0101, 11'b0);
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset holds every output low despite active inputs
    win_sel = 3'b101; host_cs = 1; host_oe = 1; host_we = 1; io_mode = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R1 outputs in reset", |outs(), 1'b0);
    rst = 0;
    for (int v = 0; v < 512; v++) drive(v[8:0]);
    // extra targeted patterns: byte card in common, protected write
    drive(9'b000_1_0_1_0_0_1);
    drive(9'b000_1_0_1_1_0_0);
    drive(9'b111_1_1_0_0_0_0);
    repeat (3) @(negedge clk);
    // R13: output moves only at the clock edge
    win_sel = 3'b000; host_cs = 1; host_oe = 1; host_we = 0; card_wp = 0;
    @(negedge clk);
    check1("R13 mem_rd after edge", mem_rd, 1'b1);
    host_cs = 0;
    #2;
    check1("R13 mem_rd held before edge", mem_rd, 1'b1);
    @(negedge clk);
    check1("R13 mem_rd cleared after edge", mem_rd, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule